// File: doc/BRIEF.md
# Flash Operation Completion Poller

After a program or erase command has been sent to a parallel flash device, this block works out when the device has finished. Once started, it reads one fixed address over and over through a simple request/response read port and checks a status bit in every returned byte. In toggle mode it compares bit 6 of each read with bit 6 of the read before. The device flips that bit while it is busy, so two equal reads in a row mean the device is done. In data-poll mode it compares bit 7 of each read with bit 7 of the byte that was written. A slow toggle variant, used after erase commands, waits a programmable number of clock cycles between the return of one read and the request for the next.

Each run ends in one of two ways: the completion condition is met, or an iteration ceiling is reached. The block then gives a one-cycle done pulse, a timeout flag, a warning flag for runs that needed many iterations, and the number of compare reads made. These results hold until the next run starts. A controlling sequencer starts a run with a one-cycle start pulse and waits for the done pulse.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o, timeout_o and warn_o are 0 and iter_o is 0.
- R2: A start_i pulse while idle begins a run and captures mode_i, addr_i and expect_i. Every read request of the run carries the captured address on rd_addr_o. A start_i pulse while busy_o is 1 is ignored.
- R3: Toggle modes (mode_i = 0 fast, mode_i = 1 slow) work as follows. The first read of a run only stores bit 6 as a reference. Each later read is a compare read, and it completes the run when its bit 6 equals bit 6 of the read just before it. All other data bits are ignored.
- R4: Data-poll modes (mode_i = 2 or 3) work as follows. Every read is a compare read, and the run completes when bit 7 of the read equals bit 7 of the captured expected byte. All other bits of both bytes are ignored.
- R5: In mode 1, the next read request is raised exactly GAP_CYC+1 clock cycles after the cycle in which the previous read's rd_valid_i was sampled high. In modes 0, 2 and 3 it is raised exactly 1 cycle after that cycle.
- R6: iter_o gives the number of compare reads in the current or last run. It is cleared by a start accepted while idle, and it does not change while idle otherwise.
- R7: If MAX_ITER compare reads finish without a match, the run ends with timeout_o = 1 and iter_o = MAX_ITER. If the MAX_ITER-th compare read matches, the run ends with timeout_o = 0. No further reads are made after the run ends.
- R8: At the end of a run, warn_o is 1 exactly when iter_o is greater than WARN_ITER.
- R9: done_o is a single-cycle pulse in the cycle after the final rd_valid_i, and busy_o is 0 from that cycle on. rd_req_o is a one-cycle pulse, and at most one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a run while idle |
| mode_i | input | 2 | 0 toggle, 1 slow toggle, 2 or 3 data poll |
| addr_i | input | AW | Address to poll |
| expect_i | input | 8 | Written data byte; only bit 7 is used |
| rd_req_o | output | 1 | Read request pulse |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data return strobe |
| rd_data_i | input | 8 | Returned read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| timeout_o | output | 1 | Last run hit the iteration ceiling |
| warn_o | output | 1 | Last run needed more than WARN_ITER compare reads |
| iter_o | output | clog2(MAX_ITER+1) | Compare reads in the current or last run |

## Verification
The assertions assume a well-behaved read port. rd_valid_i comes once per request and only while that read is outstanding, and start_i stays low during reset. The bench's flash model answers each request exactly once, after a fixed latency of one or two cycles, and never raises rd_valid_i unprompted. The only start_i pulse given during a run is the deliberate one that checks the busy-ignore rule. The model flips or holds the status bit so that completion lands on every iteration count from the first compare read up to beyond the ceiling. It fills the bits that should be ignored with changing noise.

// File: rtl/poll_pkg.sv
package poll_pkg;

    localparam int unsigned RD_W       = 8;
    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned MATCH_BIT  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GAP   = 2'd3
    } poll_state_e;

    localparam logic [1:0] MODE_TOGGLE_SLOW = 2'd1;

    // mode codes 2 and 3 both select data polling
    function automatic logic mode_is_data(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/poll_gap_timer.sv
module poll_gap_timer #(
    parameter int unsigned GAP_CYC = 2000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expire_o
);
    localparam int unsigned GW = $clog2(GAP_CYC + 1);
    localparam logic [GW-1:0] LAST = GW'(GAP_CYC - 1);

    logic [GW-1:0] cnt_d, cnt_q;

    // counts the cycles spent waiting; restarts from zero whenever idle
    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/poll_bit_judge.sv
module poll_bit_judge (
    input  logic is_data_i,
    input  logic tog_bit_i,
    input  logic poll_bit_i,
    input  logic ref_bit_i,
    input  logic exp_bit_i,
    output logic match_o
);
    logic toggle_still;
    logic poll_hit;

    always_comb begin
        toggle_still = (tog_bit_i == ref_bit_i);
        poll_hit     = (poll_bit_i == exp_bit_i);
        match_o      = is_data_i ? poll_hit : toggle_still;
    end

endmodule

// File: rtl/poll_iter_counter.sv
module poll_iter_counter #(
    parameter int unsigned MAX_ITER  = 32'h0FFF_FFFF,
    parameter int unsigned WARN_ITER = 32'h0010_0000
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               clr_i,
    input  logic                               inc_i,
    output logic [$clog2(MAX_ITER + 1)-1:0]    count_o,
    output logic                               last_o,
    output logic                               beyond_warn_o
);
    localparam int unsigned IW = $clog2(MAX_ITER + 1);
    localparam logic [IW-1:0] TOP = IW'(MAX_ITER);
    localparam logic [IW-1:0] PRE = IW'(MAX_ITER - 1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o       = cnt_q;
    // the read being counted now is the final one allowed
    assign last_o        = (cnt_q == PRE);
    // after the pending increment the total exceeds the warning level
    assign beyond_warn_o = (32'(cnt_q) >= WARN_ITER);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import poll_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned MAX_ITER  = 32'h0FFF_FFFF,
    parameter int unsigned WARN_ITER = 32'h0010_0000,
    parameter int unsigned GAP_CYC   = 2000000
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            start_i,
    input  logic [1:0]                      mode_i,
    input  logic [AW-1:0]                   addr_i,
    input  logic [RD_W-1:0]                 expect_i,
    output logic                            rd_req_o,
    output logic [AW-1:0]                   rd_addr_o,
    input  logic                            rd_valid_i,
    input  logic [RD_W-1:0]                 rd_data_i,
    output logic                            busy_o,
    output logic                            done_o,
    output logic                            timeout_o,
    output logic                            warn_o,
    output logic [$clog2(MAX_ITER + 1)-1:0] iter_o
);
    localparam int unsigned IW = $clog2(MAX_ITER + 1);

    typedef struct packed {
        poll_state_e   state;
        logic          is_data;
        logic          slow;
        logic [AW-1:0] addr;
        logic          exp_bit;
        logic          ref_bit;
        logic          have_ref;
        logic          done;
        logic          timeout;
        logic          warn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          cnt_clr, cnt_inc;
    logic          cnt_last, cnt_beyond;
    logic [IW-1:0] cnt_val;
    logic          gap_run, gap_expire;
    logic          hit;
    logic          unused_bits;

    assign unused_bits = ^{rd_data_i[5:0], expect_i[6:0]};

    poll_gap_timer #(
        .GAP_CYC(GAP_CYC)
    ) u_gap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (gap_run),
        .expire_o(gap_expire)
    );

    poll_bit_judge u_judge (
        .is_data_i (ctl_q.is_data),
        .tog_bit_i (rd_data_i[TOGGLE_BIT]),
        .poll_bit_i(rd_data_i[MATCH_BIT]),
        .ref_bit_i (ctl_q.ref_bit),
        .exp_bit_i (ctl_q.exp_bit),
        .match_o   (hit)
    );

    poll_iter_counter #(
        .MAX_ITER (MAX_ITER),
        .WARN_ITER(WARN_ITER)
    ) u_iter (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clr_i        (cnt_clr),
        .inc_i        (cnt_inc),
        .count_o      (cnt_val),
        .last_o       (cnt_last),
        .beyond_warn_o(cnt_beyond)
    );

    always_comb begin
        poll_state_e follow;

        ctl_d   = ctl_q;
        ctl_d.done = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        gap_run = (ctl_q.state == ST_GAP);
        follow  = ctl_q.slow ? ST_GAP : ST_ISSUE;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.state    = ST_ISSUE;
                    ctl_d.is_data  = mode_is_data(mode_i);
                    ctl_d.slow     = (mode_i == MODE_TOGGLE_SLOW);
                    ctl_d.addr     = addr_i;
                    ctl_d.exp_bit  = expect_i[MATCH_BIT];
                    ctl_d.have_ref = 1'b0;
                    ctl_d.timeout  = 1'b0;
                    ctl_d.warn     = 1'b0;
                    cnt_clr        = 1'b1;
                end
            end
            ST_ISSUE: begin
                ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_valid_i) begin
                    if (!ctl_q.is_data && !ctl_q.have_ref) begin
                        // reference read: nothing to compare against yet
                        ctl_d.have_ref = 1'b1;
                        ctl_d.ref_bit  = rd_data_i[TOGGLE_BIT];
                        ctl_d.state    = follow;
                    end else begin
                        cnt_inc = 1'b1;
                        if (hit || cnt_last) begin
                            ctl_d.state   = ST_IDLE;
                            ctl_d.done    = 1'b1;
                            ctl_d.timeout = !hit;
                            ctl_d.warn    = cnt_beyond;
                        end else begin
                            ctl_d.ref_bit = rd_data_i[TOGGLE_BIT];
                            ctl_d.state   = follow;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_expire) begin
                    ctl_d.state = ST_ISSUE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_o  = (ctl_q.state == ST_ISSUE);
    assign rd_addr_o = ctl_q.addr;
    assign busy_o    = (ctl_q.state != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign timeout_o = ctl_q.timeout;
    assign warn_o    = ctl_q.warn;
    assign iter_o    = cnt_val;

endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk #(
    parameter int unsigned AW        = 16,
    parameter int unsigned MAX_ITER  = 32'h0FFF_FFFF,
    parameter int unsigned WARN_ITER = 32'h0010_0000
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic                            start_i,
    input logic                            rd_req_o,
    input logic [AW-1:0]                   rd_addr_o,
    input logic                            rd_valid_i,
    input logic                            busy_o,
    input logic                            done_o,
    input logic                            timeout_o,
    input logic                            warn_o,
    input logic [$clog2(MAX_ITER + 1)-1:0] iter_o
);

    assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o);

    assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_after_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(rd_valid_i));

    assert_iter_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(iter_o) <= MAX_ITER);

    assert_timeout_at_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && timeout_o) |-> (32'(iter_o) == MAX_ITER));

    assert_warn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (warn_o == (32'(iter_o) > WARN_ITER)));

    assert_addr_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

    assert_iter_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !$past(busy_o) && !$past(start_i)) |-> $stable(iter_o));

endmodule

bind flash_done_poller flash_done_poller_chk #(
    .AW       (AW),
    .MAX_ITER (MAX_ITER),
    .WARN_ITER(WARN_ITER)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_valid_i(rd_valid_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .timeout_o (timeout_o),
    .warn_o    (warn_o),
    .iter_o    (iter_o)
);

// File: tb/flash_done_poller_bench.sv
`timescale 1ns/1ps
module flash_done_poller_bench;
    localparam int AW   = 8;
    localparam int MAXI = 12;
    localparam int WARN = 5;
    localparam int GAP  = 4;
    localparam int IW   = $clog2(MAXI + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    expv = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_valid = 1'b0;
    logic [7:0]    rd_data = '0;
    logic          busy, done, tmo, warn;
    logic [IW-1:0] iter;

    int checks = 0;
    int fails  = 0;

    // flash model state
    int            cur_B = 0;
    logic          cur_data = 1'b0;
    logic          cur_e7 = 1'b0;
    logic [7:0]    cur_seed = 8'h00;
    int            lat = 1;
    logic [AW-1:0] exp_addr = '0;
    int            pend = 0;
    int            rd_idx = 0;
    int            addr_err = 0;
    int            cyc = 0;
    int            vt = 0;
    int            gmin = 1000;
    int            gmax = 0;
    int            g;

    always #2 clk = ~clk;

    flash_done_poller #(
        .AW(AW), .MAX_ITER(MAXI), .WARN_ITER(WARN), .GAP_CYC(GAP)
    ) u_flash_done_poller (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .addr_i(addr), .expect_i(expv), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_valid_i(rd_valid), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
        .timeout_o(tmo), .warn_o(warn), .iter_o(iter)
    );

    // toggle: bit 6 flips for reads 0..B, then holds; data: bit 7 wrong for B reads
    function automatic logic [7:0] mdata(input int k);
        logic [7:0] v;
        v = 8'(k * 37 + 11) ^ cur_seed;
        if (!cur_data) v[6] = (k <= cur_B) ? k[0] : cur_B[0];
        else           v[7] = (k < cur_B) ? ~cur_e7 : cur_e7;
        return v;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_valid <= 1'b0;
        if (rd_valid) vt <= cyc;
        if (pend != 0) begin
            pend <= pend - 1;
            if (pend == 1) begin
                rd_valid <= 1'b1;
                rd_data  <= mdata(rd_idx - 1);
            end
        end
        if (rd_req) begin
            pend   <= lat;
            rd_idx <= rd_idx + 1;
            if (rd_addr != exp_addr) addr_err <= addr_err + 1;
            if (rd_idx != 0) begin
                g = cyc - vt;
                if (g < gmin) gmin <= g;
                if (g > gmax) gmax <= g;
            end
        end
        if (start && !busy) begin
            rd_idx <= 0; addr_err <= 0; gmin <= 1000; gmax <= 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expd);
        end
    endtask

    task automatic run_case(input int m, input int b, input bit e7, input int l,
                            input logic [AW-1:0] a, input bit poke);
        int it, reads, egap, n, held;
        bit to, wr, seen;
        cur_B = b; cur_data = m[1]; cur_e7 = e7; lat = l; exp_addr = a;
        cur_seed = 8'(b * 13 + m * 5 + l);
        it    = (b + 1 > MAXI) ? MAXI : b + 1;
        to    = (b + 1 > MAXI);
        wr    = (it > WARN);
        reads = m[1] ? it : it + 1;
        egap  = (m == 1) ? GAP + 1 : 1;
        @(negedge clk);
        start = 1'b1; mode = 2'(m); addr = a; expv = {e7, 7'(b * 29 + 3)};
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; mode = 2'd2; addr = ~a; expv = ~expv;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0;
        n = 0;
        while (!seen && n < 3000) begin
            if (done) seen = 1'b1;
            else begin @(negedge clk); n++; end
        end
        chk(seen, "R9 done reached", int'(seen), 1);
        chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
        if (m[1]) chk(int'(iter) == it, "R4 iter", int'(iter), it);
        else      chk(int'(iter) == it, "R3 iter", int'(iter), it);
        chk(tmo == to, "R7 timeout", int'(tmo), int'(to));
        chk(warn == wr, "R8 warn", int'(warn), int'(wr));
        chk(rd_idx == reads, "R7 read count", rd_idx, reads);
        chk(addr_err == 0, "R2 address", addr_err, 0);
        if (reads >= 2) begin
            chk(gmin == egap && gmax == egap, "R5 gap", gmin, egap);
        end
        @(negedge clk);
        chk(done == 1'b0, "R9 done pulse", int'(done), 0);
        held = rd_idx;
        repeat (4) @(negedge clk);
        chk(int'(iter) == it, "R6 iter hold", int'(iter), it);
        chk(rd_idx == held, "R7 no reads after end", rd_idx, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, rd_req, tmo, warn} == 5'b0, "R1 reset flags",
            int'({busy, done, rd_req, tmo, warn}), 0);
        chk(iter == '0, "R1 reset iter", int'(iter), 0);

        run_case(1, 6, 1'b0, 2, 8'h5A, 1'b1);
        run_case(0, 3, 1'b1, 1, 8'hC3, 1'b1);

        for (int m = 0; m < 4; m++)
            for (int b = 0; b < 14; b++)
                for (int e = 0; e < 2; e++)
                    for (int l = 1; l < 3; l++)
                        run_case(m, b, e[0], l, 8'(m * 64 + b * 7 + e), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule